// File: doc/BRIEF.md
# Banked Scratchpad Read Conflict Arbiter

This block serves one group's batch of per-thread read requests to a local scratchpad made of several single-port banks, with consecutive words spread across banks in turn. On a start strobe it takes in every thread's word address and valid bit. It works out each thread's bank from the address and then issues reads bank by bank. In any cycle a bank serves one distinct address. All threads that asked for that exact address are answered together by broadcast. Different addresses that fall on the same bank are served in turn over later cycles.

While any accepted thread is still waiting, the block holds a group stall high. The issuing group cannot be replaced in the meantime. Each thread's data lands in a registered output with its own done flag. A batch whose worst bank has k distinct addresses takes k read cycles, so the stall lasts k+1 cycles, counting the read pipeline. The scratchpad holds fixed content that can be computed from the address, and the block never writes it.

Top module: `lmca_top`

## Requirements
- R1: With NBANK banks, word address A lives in bank A mod NBANK at row A / NBANK. With DW=32, the word read for address A equals (A * 0x9E3779B1) mod 2^32.
- R2: After reset, stall_o is 0, every done_o bit is 0 and every data_o lane is 0.
- R3: A start is accepted on a clock edge where start_i=1, stall_o=0 and valid_i is non-zero. Acceptance clears all done_o bits and raises stall_o after that edge.
- R4: In each cycle a bank reads one address: the address of the lowest-numbered thread still waiting on that bank. Every waiting thread with that same address is served in that read.
- R5: Let k be the largest number of distinct addresses requested on any one bank. stall_o stays high for exactly k+1 cycles after the accepting edge, and falls on the edge where the last done_o bit is set.
- R6: When all valid threads use one address, or when all of them hit different banks, k=1 and the batch completes two edges after acceptance.
- R7: Rank each distinct address on a bank by the lowest thread index that requests it, counting from 0. A thread whose address has rank r gets done_o set on the (r+2)-th edge after acceptance.
- R8: A thread whose valid_i bit was 0 at acceptance never gets done_o set in that batch.
- R9: A start_i pulse while stall_o is high is ignored. The running batch's timing, done flags and data are unchanged.
- R10: A start_i with valid_i all zero is ignored. stall_o stays 0 and done_o keeps its value.
- R11: When done_o[t] is set, lane t of data_o holds the R1 word for thread t's address, and it keeps that value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe for a new batch |
| valid_i | input | NTHR | Per-thread request valid |
| addr_i | input | NTHR*AW | Per-thread word address, thread t in bits [t*AW +: AW] |
| data_o | output | NTHR*DW | Per-thread read data, thread t in bits [t*DW +: DW] |
| done_o | output | NTHR | Per-thread data returned flag |
| stall_o | output | 1 | Group stall while any accepted thread is waiting |

## Verification
The assertions assume that the group presents a new batch only while stall_o is low. They also assume that addr_i and valid_i are stable at the accepting edge. They assume NBANK is a power of two. The stimulus drives every input on the falling edge and lowers start_i one cycle after acceptance, except in one deliberate test that pulses start_i during a stall. All addresses stay inside the AW-bit space. The vectors cover bank-disjoint, broadcast, fully serialized, mixed duplicate and partially valid batches, so that the rank timing of R7 is tested at depths from 1 to 8.

// File: rtl/lmca_pkg.sv
package lmca_pkg;

  localparam logic [31:0] FILL_MULT = 32'h9E3779B1;

  // Fixed scratchpad content as a function of the word address.
  function automatic logic [31:0] fill_word(input logic [31:0] addr);
    return addr * FILL_MULT;
  endfunction

endpackage

// File: rtl/lmca_bank.sv
module lmca_bank #(
  parameter int DW      = 32,
  parameter int RW      = 5,
  parameter int NBANK   = 8,
  parameter int BANK_ID = 0
) (
  input  logic          clk,
  input  logic          rd_en_i,
  input  logic [RW-1:0] rd_row_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int ROWS = 1 << RW;

  logic [DW-1:0] mem [ROWS];

  initial begin
    for (int r = 0; r < ROWS; r++) begin
      mem[r] = DW'(lmca_pkg::fill_word(32'(r * NBANK + BANK_ID)));
    end
  end

  // One-cycle registered read, block RAM style.
  always_ff @(posedge clk) begin
    if (rd_en_i) rd_data_o <= mem[rd_row_i];
  end

endmodule

// File: rtl/lmca_pick.sv
module lmca_pick #(
  parameter int NTHR = 8,
  parameter int AW   = 8,
  parameter int BW   = 3,
  parameter int BANK = 0
) (
  input  logic [NTHR-1:0]    pend_i,
  input  logic [NTHR*AW-1:0] addr_i,
  output logic               sel_v_o,
  output logic [AW-1:0]      sel_addr_o
);
  // Lowest-numbered pending thread on this bank wins: scan downward so it overwrites.
  always_comb begin
    sel_v_o    = 1'b0;
    sel_addr_o = '0;
    for (int t = NTHR - 1; t >= 0; t--) begin
      if (pend_i[t] && (addr_i[t*AW +: BW] == BW'(BANK))) begin
        sel_v_o    = 1'b1;
        sel_addr_o = addr_i[t*AW +: AW];
      end
    end
  end

endmodule

// File: rtl/lmca_top.sv
module lmca_top #(
  parameter int NTHR  = 8,
  parameter int NBANK = 8,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [NTHR-1:0]    valid_i,
  input  logic [NTHR*AW-1:0] addr_i,
  output logic [NTHR*DW-1:0] data_o,
  output logic [NTHR-1:0]    done_o,
  output logic               stall_o
);
  localparam int BW  = $clog2(NBANK);
  localparam int RW  = AW - BW;
  localparam int CW  = $clog2(NTHR + 3);

  logic [NTHR*AW-1:0] addr_q;
  logic [NTHR-1:0]    valid_q;
  logic [NTHR-1:0]    pend_q;
  logic [NTHR-1:0]    ret_q;
  logic [NTHR-1:0]    done_q;
  logic [NTHR*DW-1:0] data_q;
  logic               stall_q;

  logic [NBANK-1:0]   sel_v;
  logic [AW-1:0]      sel_addr [NBANK];
  logic [DW-1:0]      rdat     [NBANK];
  logic [NTHR-1:0]    served;
  logic               accept;

  assign accept = start_i && !stall_q && (|valid_i);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    lmca_pick #(.NTHR(NTHR), .AW(AW), .BW(BW), .BANK(b)) i_pick (
      .pend_i     (pend_q),
      .addr_i     (addr_q),
      .sel_v_o    (sel_v[b]),
      .sel_addr_o (sel_addr[b])
    );
    lmca_bank #(.DW(DW), .RW(RW), .NBANK(NBANK), .BANK_ID(b)) i_bank (
      .clk       (clk),
      .rd_en_i   (sel_v[b]),
      .rd_row_i  (sel_addr[b][AW-1:BW]),
      .rd_data_o (rdat[b])
    );
  end

  // A thread is served when its bank's chosen address is exactly its own (broadcast).
  always_comb begin
    for (int t = 0; t < NTHR; t++) begin
      served[t] = pend_q[t] && sel_v[addr_q[t*AW +: BW]] &&
                  (sel_addr[addr_q[t*AW +: BW]] == addr_q[t*AW +: AW]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      valid_q <= '0;
      pend_q  <= '0;
      ret_q   <= '0;
      done_q  <= '0;
      data_q  <= '0;
      stall_q <= 1'b0;
    end else begin
      ret_q  <= served;
      pend_q <= pend_q & ~served;
      for (int t = 0; t < NTHR; t++) begin
        if (ret_q[t]) begin
          data_q[t*DW +: DW] <= rdat[addr_q[t*AW +: BW]];
          done_q[t]          <= 1'b1;
        end
      end
      if (accept) begin
        addr_q  <= addr_i;
        valid_q <= valid_i;
        pend_q  <= valid_i;
        ret_q   <= '0;
        done_q  <= '0;
        stall_q <= 1'b1;
      end else if (stall_q && (|ret_q) && (pend_q == '0)) begin
        stall_q <= 1'b0;
      end
    end
  end

  assign data_o  = data_q;
  assign done_o  = done_q;
  assign stall_o = stall_q;

  // Stall run length, used to bound latency.
  logic [CW-1:0] stall_run;
  always_ff @(posedge clk) begin
    if (rst)          stall_run <= '0;
    else if (stall_q) stall_run <= stall_run + 1'b1;
    else              stall_run <= '0;
  end

  a_r3_stall_needs_start: assert property (@(posedge clk) disable iff (rst)
    $rose(stall_q) |-> $past(start_i));

  a_r5_done_at_release: assert property (@(posedge clk) disable iff (rst)
    $fell(stall_q) |-> (done_q == valid_q));

  a_r5_stall_bound: assert property (@(posedge clk) disable iff (rst)
    stall_run <= CW'(NTHR + 1));

  a_r7_done_only_busy: assert property (@(posedge clk) disable iff (rst)
    (|(done_q & ~$past(done_q))) |-> $past(stall_q));

  a_r8_invalid_never_done: assert property (@(posedge clk) disable iff (rst)
    (done_q & ~valid_q) == '0);

  a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (stall_q && start_i) |=> ((done_q & $past(done_q)) == $past(done_q)));

endmodule

// File: tb/test_lmca_top.sv
module test_lmca_top;
  localparam int NT = 8;
  localparam int AW = 8;
  localparam int DW = 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [NT-1:0]    valid = '0;
  logic [NT*AW-1:0] addr = '0;
  logic [NT*DW-1:0] data;
  logic [NT-1:0]    done;
  logic             stall;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cycles++;

  lmca_top #(.NTHR(NT), .NBANK(8), .AW(AW), .DW(DW)) i_lmca_top (
    .clk(clk), .rst(rst), .start_i(start), .valid_i(valid), .addr_i(addr),
    .data_o(data), .done_o(done), .stall_o(stall)
  );

  // {valid, addr7 .. addr0}
  localparam logic [71:0] VEC [8] = '{
    {8'hFF, 8'h07, 8'h06, 8'h05, 8'h04, 8'h03, 8'h02, 8'h01, 8'h00},
    {8'hFF, 8'h2A, 8'h2A, 8'h2A, 8'h2A, 8'h2A, 8'h2A, 8'h2A, 8'h2A},
    {8'hFF, 8'h38, 8'h30, 8'h28, 8'h20, 8'h18, 8'h10, 8'h08, 8'h00},
    {8'hFF, 8'h07, 8'h06, 8'h05, 8'h0B, 8'h03, 8'h11, 8'h09, 8'h01},
    {8'hFF, 8'h44, 8'h44, 8'h10, 8'h20, 8'h18, 8'h10, 8'h18, 8'h10},
    {8'hA5, 8'h3A, 8'h32, 8'h2A, 8'h22, 8'h1A, 8'h12, 8'h0A, 8'h02},
    {8'hFF, 8'h19, 8'h18, 8'h17, 8'h16, 8'h15, 8'h14, 8'h13, 8'h12},
    {8'hFF, 8'hF8, 8'hF9, 8'hFA, 8'hFB, 8'hFC, 8'hFD, 8'hFE, 8'hFF}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [7:0] a);
    logic [31:0] x;
    x = {24'd0, a};
    return x * 32'h9E3779B1;
  endfunction

  // Run one batch; optionally poke start during the stall (R9).
  task automatic run_vec(input logic [7:0] v, input logic [63:0] a, input bit poke);
    int rank [NT];
    int k;
    logic [NT-1:0] exp_done;
    k = 0;
    for (int t = 0; t < NT; t++) begin
      int f;
      int cnt;
      rank[t] = -1;
      if (!v[t]) continue;
      f = t;
      for (int s = 0; s < t; s++)
        if (v[s] && a[s*8 +: 8] == a[t*8 +: 8] && f == t) f = s;
      cnt = 0;
      for (int s = 0; s < f; s++) begin
        bit first;
        if (!v[s] || (a[s*8 +: 3] != a[t*8 +: 3])) continue;
        first = 1'b1;
        for (int u = 0; u < s; u++)
          if (v[u] && a[u*8 +: 8] == a[s*8 +: 8]) first = 1'b0;
        if (first) cnt++;
      end
      rank[t] = cnt;
      if (cnt + 1 > k) k = cnt + 1;
    end
    @(negedge clk);
    start = 1'b1; valid = v; addr = a;
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j <= k + 1; j++) begin
      if (poke && j == 0) begin start = 1'b1; valid = 8'hFF; addr = {8{8'h55}}; end
      if (poke && j == 1) begin start = 1'b0; valid = '0; end
      for (int t = 0; t < NT; t++) exp_done[t] = v[t] && (rank[t] + 2 <= j);
      check(stall == (j <= k), poke ? "R9 stall" : "R5 stall", 64'(stall), 64'(j <= k));
      check(done == exp_done, poke ? "R9 done" : "R7 done timing", 64'(done), 64'(exp_done));
      if (j <= k) @(negedge clk);
    end
    for (int t = 0; t < NT; t++)
      if (v[t])
        check(data[t*DW +: DW] == exp_word(a[t*8 +: 8]), "R11 R1 data",
              64'(data[t*DW +: DW]), 64'(exp_word(a[t*8 +: 8])));
      else
        check(!done[t], "R8 invalid", 64'(done[t]), 64'd0);
  endtask

  initial begin
    wait (cycles >= 20000);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=<20000", cycles);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(stall == 1'b0, "R2 stall", 64'(stall), 64'd0);
    check(done == '0, "R2 done", 64'(done), 64'd0);
    check(data == '0, "R2 data", 64'(data[63:0]), 64'd0);

    // Vector table: R4 R5 R6 R7 R1 R11 R8
    for (int i = 0; i < 8; i++) run_vec(VEC[i][71:64], VEC[i][63:0], 1'b0);

    // R10: start with no valid thread is ignored
    @(negedge clk);
    start = 1'b1; valid = '0; addr = {8{8'h33}};
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j < 3; j++) begin
      check(stall == 1'b0, "R10 stall", 64'(stall), 64'd0);
      check(done == 8'hFF, "R10 done kept", 64'(done), 64'hFF);
      @(negedge clk);
    end

    // R9: start during stall is ignored (batch with k=3)
    run_vec(VEC[3][71:64], VEC[3][63:0], 1'b1);

    // R6: broadcast again after a conflicting batch
    run_vec(8'hFF, {8{8'hC3}}, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule